// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a double-data-rate SDRAM and takes the memory from power application to an idle, programmed state. After reset it keeps clock enable low and drives no-operation on the command pins while a power-stable delay runs. It then raises clock enable and issues a fixed series of commands. The series is: close all banks, write the extended register, write the base register with the DLL reset bit set, a parameterized number of auto refreshes, and a last base register write with DLL reset cleared. When the last command's settling gap has run out, it raises a done flag. Normal traffic can then be handed over.

The DLL governs the order of the series. The extended register has no defined value at power-up, so it is always written, with DLL enable and the chosen driver strength, before the DLL is reset through the base register. All delays (power-stable wait, precharge gap, register-write gap, refresh spacing, refresh count) and all mode fields are parameters. Command pins are registered and change only on rising clock edges.

Command pins below are listed as {csN, rasN, casN, weN}. NOP is 0111, precharge is 0010, auto refresh is 0001, and register write is 0000.

Top module: `dram_pwrup_seq`

## Requirements
- R1: While reset is held, and after it is released until clock enable rises, cke is 0, done is 0 and the command pins show NOP (0111). After reset is released, cke rises on the STABLE_CYC-th rising clock edge.
- R2: The first command is precharge-all: 0010 with addr bit 10 set and all other address and bank bits zero. It appears on the edge after cke rises.
- R3: The extended register write is 0000 with ba = 01. In its address, bit 0 = 0 (DLL enabled), bit 1 = HALF_DRV and every other bit is 0. It appears TRP edges after the precharge.
- R4: The DLL-reset register write is 0000 with ba = 00. Its address carries bits [2:0] = BL_CODE, bit 3 = BT, bits [6:4] = CL_CODE and bit 8 = 1, with every other bit 0. It appears TMRD edges after the extended register write.
- R5: Exactly REF_NUM auto refreshes (0001, ba and addr zero) follow. The first comes TMRD edges after the R4 write, and each later one comes TRFC edges after the one before it.
- R6: The final register write carries the same fields as R4 but with bit 8 = 0. It appears TRFC edges after the last refresh.
- R7: done rises TMRD edges after the final register write. It then stays high, and the command pins stay NOP, until reset.
- R8: Every non-NOP command lasts exactly one cycle. The pins show NOP on every cycle between commands.
- R9: Once cke is high it stays high until reset.
- R10: A reset applied at any point, including mid-sequence or after done, returns the outputs to the R1 state at once. After release, the whole series restarts from the power-stable wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; all outputs change on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address; selects the target register during register writes |
| addr | output | ADDR_W | Address bus; carries the register contents and the all-banks bit |
| done | output | 1 | High once the initialization series has completed |

## Verification
One same-cycle case matters. During a refresh wait, the gap timer can run out in the same cycle that the refresh tally reaches its last value. On that cycle the sequencer must branch to the final register write and not issue another refresh. The bench reaches this case on every run through the default series. It judges the result by requiring exactly REF_NUM refreshes, a final register write with the DLL reset bit clear, and the exact TRFC spacing before that write. A second coincidence arises when reset lands while a refresh gap is counting. The bench aborts a run at that point, checks the outputs right away, and then requires a complete, correctly timed restart.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

  // Kind of command placed on the pins in the next cycle
  typedef enum logic [2:0] {
    K_NOP,
    K_PRE_ALL,
    K_EXT_WR,
    K_BASE_DLLRST,
    K_REFRESH,
    K_BASE_RUN
  } cmdKind_t;

  // Which gap is loaded into the wait timer
  typedef enum logic [1:0] {
    G_RP,
    G_MRD,
    G_RFC
  } gapSel_t;

  typedef enum logic [3:0] {
    S_STABLE,
    S_PRE,
    S_W_PRE,
    S_EXT,
    S_W_EXT,
    S_DLL,
    S_W_DLL,
    S_REF,
    S_W_REF,
    S_RUN,
    S_W_RUN,
    S_DONE
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    cmdKind_t kind;
    gapSel_t  gap;
    logic     cntLoad;
    logic     refLoad;
    logic     refDec;
    logic     ckeOn;
    logic     doneOn;
  } dpuStrobe_t;

  // Pin codes {csN, rasN, casN, weN}
  localparam logic [3:0] PIN_NOP = 4'b0111;
  localparam logic [3:0] PIN_PRE = 4'b0010;
  localparam logic [3:0] PIN_REF = 4'b0001;
  localparam logic [3:0] PIN_MRW = 4'b0000;

endpackage

// File: rtl/dpu_ctrl.sv
module dpu_ctrl
  import dpu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntZero,
  input  logic       refLast,
  output dpuStrobe_t stb
);

  seqState_t state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_STABLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt         = state;
    stb         = '0;
    stb.kind    = K_NOP;
    stb.gap     = G_MRD;
    unique case (state)
      S_STABLE: if (cntZero) nxt = S_PRE;
      S_PRE: begin
        stb.kind    = K_PRE_ALL;
        stb.gap     = G_RP;
        stb.cntLoad = 1'b1;
        nxt         = S_W_PRE;
      end
      S_W_PRE: if (cntZero) nxt = S_EXT;
      S_EXT: begin
        stb.kind    = K_EXT_WR;
        stb.gap     = G_MRD;
        stb.cntLoad = 1'b1;
        nxt         = S_W_EXT;
      end
      S_W_EXT: if (cntZero) nxt = S_DLL;
      S_DLL: begin
        stb.kind    = K_BASE_DLLRST;
        stb.gap     = G_MRD;
        stb.cntLoad = 1'b1;
        stb.refLoad = 1'b1;
        nxt         = S_W_DLL;
      end
      S_W_DLL: if (cntZero) nxt = S_REF;
      S_REF: begin
        stb.kind    = K_REFRESH;
        stb.gap     = G_RFC;
        stb.cntLoad = 1'b1;
        stb.refDec  = 1'b1;
        nxt         = S_W_REF;
      end
      S_W_REF: if (cntZero) nxt = refLast ? S_RUN : S_REF;
      S_RUN: begin
        stb.kind    = K_BASE_RUN;
        stb.gap     = G_MRD;
        stb.cntLoad = 1'b1;
        nxt         = S_W_RUN;
      end
      S_W_RUN: if (cntZero) nxt = S_DONE;
      S_DONE:  stb.doneOn = 1'b1;
      default: nxt = S_STABLE;
    endcase
    // clock enable goes high one edge ahead of the first command
    stb.ckeOn = (nxt != S_STABLE);
  end

endmodule

// File: rtl/dpu_path.sv
module dpu_path
  import dpu_pkg::*;
#(
  parameter int          STABLE_CYC = 40,
  parameter int          TRP        = 3,
  parameter int          TMRD       = 2,
  parameter int          TRFC       = 8,
  parameter int          REF_NUM    = 2,
  parameter int          ADDR_W     = 13,
  parameter int          BA_W       = 2,
  parameter logic [2:0]  BL_CODE    = 3'b010,
  parameter logic        BT         = 1'b0,
  parameter logic [2:0]  CL_CODE    = 3'b011,
  parameter logic        HALF_DRV   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpuStrobe_t        stb,
  output logic              cntZero,
  output logic              refLast,
  output logic              ckeQ,
  output logic [3:0]        pinQ,
  output logic [BA_W-1:0]   baQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              doneQ
);

  localparam int M1    = (STABLE_CYC > TRP) ? STABLE_CYC : TRP;
  localparam int M2    = (TMRD > TRFC) ? TMRD : TRFC;
  localparam int MAXV  = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXV + 1);
  localparam int REF_W = $clog2(REF_NUM + 1);

  localparam int BIT_ALLBANK = 10;
  localparam int BIT_DLLRST  = 8;

  localparam logic [ADDR_W-1:0] MODE_WORD =
      (ADDR_W'(CL_CODE) << 4) | (ADDR_W'(BT) << 3) | ADDR_W'(BL_CODE);
  localparam logic [ADDR_W-1:0] EXT_WORD  = ADDR_W'(HALF_DRV) << 1;
  localparam logic [ADDR_W-1:0] ALL_WORD  = ADDR_W'(1) << BIT_ALLBANK;
  localparam logic [ADDR_W-1:0] RST_WORD  = MODE_WORD | (ADDR_W'(1) << BIT_DLLRST);

  logic [CNT_W-1:0] cnt, loadVal;
  logic [REF_W-1:0] refCnt;

  // gap timer: counts command-to-command distance minus two
  always_comb begin
    unique case (stb.gap)
      G_RP:    loadVal = CNT_W'(TRP - 2);
      G_RFC:   loadVal = CNT_W'(TRFC - 2);
      default: loadVal = CNT_W'(TMRD - 2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= CNT_W'(STABLE_CYC - 1);
    else if (stb.cntLoad)  cnt <= loadVal;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            refCnt <= '0;
    else if (stb.refLoad) refCnt <= REF_W'(REF_NUM);
    else if (stb.refDec)  refCnt <= refCnt - 1'b1;
  end

  assign refLast = (refCnt == '0);

  logic [3:0]        pinD;
  logic [BA_W-1:0]   baD;
  logic [ADDR_W-1:0] addrD;

  always_comb begin
    pinD  = PIN_NOP;
    baD   = '0;
    addrD = '0;
    unique case (stb.kind)
      K_PRE_ALL: begin
        pinD  = PIN_PRE;
        addrD = ALL_WORD;
      end
      K_EXT_WR: begin
        pinD  = PIN_MRW;
        baD   = BA_W'(1);
        addrD = EXT_WORD;
      end
      K_BASE_DLLRST: begin
        pinD  = PIN_MRW;
        addrD = RST_WORD;
      end
      K_REFRESH:  pinD = PIN_REF;
      K_BASE_RUN: begin
        pinD  = PIN_MRW;
        addrD = MODE_WORD;
      end
      default: pinD = PIN_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckeQ  <= 1'b0;
      pinQ  <= PIN_NOP;
      baQ   <= '0;
      addrQ <= '0;
      doneQ <= 1'b0;
    end else begin
      ckeQ  <= stb.ckeOn;
      pinQ  <= pinD;
      baQ   <= baD;
      addrQ <= addrD;
      doneQ <= stb.doneOn;
    end
  end

endmodule

// File: rtl/dram_pwrup_seq.sv
module dram_pwrup_seq
  import dpu_pkg::*;
#(
  parameter int          STABLE_CYC = 40,
  parameter int          TRP        = 3,
  parameter int          TMRD       = 2,
  parameter int          TRFC       = 8,
  parameter int          REF_NUM    = 2,
  parameter int          ADDR_W     = 13,
  parameter int          BA_W       = 2,
  parameter logic [2:0]  BL_CODE    = 3'b010,
  parameter logic        BT         = 1'b0,
  parameter logic [2:0]  CL_CODE    = 3'b011,
  parameter logic        HALF_DRV   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  dpuStrobe_t stb;
  logic       cntZero, refLast;
  logic [3:0] pinQ;

  dpu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cntZero (cntZero),
    .refLast (refLast),
    .stb     (stb)
  );

  dpu_path #(
    .STABLE_CYC (STABLE_CYC),
    .TRP        (TRP),
    .TMRD       (TMRD),
    .TRFC       (TRFC),
    .REF_NUM    (REF_NUM),
    .ADDR_W     (ADDR_W),
    .BA_W       (BA_W),
    .BL_CODE    (BL_CODE),
    .BT         (BT),
    .CL_CODE    (CL_CODE),
    .HALF_DRV   (HALF_DRV)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cntZero (cntZero),
    .refLast (refLast),
    .ckeQ    (cke),
    .pinQ    (pinQ),
    .baQ     (ba),
    .addrQ   (addr),
    .doneQ   (done)
  );

  assign {csN, rasN, casN, weN} = pinQ;

endmodule

// File: rtl/dpu_chk.sv
module dpu_chk #(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);

  logic [3:0] pins;
  assign pins = {csN, rasN, casN, weN};

  a_r1_idle_while_cke_low: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (pins == 4'b0111 && !done));

  a_r2_precharge_after_cke: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |=> (pins == 4'b0010 && addr[10]));

  a_r3_ext_dll_enabled: assert property (@(posedge clk) disable iff (!rstN)
    (pins == 4'b0000 && ba == BA_W'(1)) |-> !addr[0]);

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pins == 4'b0111);

  a_r8_one_cycle_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (pins != 4'b0111) |=> (pins == 4'b0111));

  a_r9_cke_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> cke);

endmodule

bind dram_pwrup_seq dpu_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .cke  (cke),
  .csN  (csN),
  .rasN (rasN),
  .casN (casN),
  .weN  (weN),
  .ba   (ba),
  .addr (addr),
  .done (done)
);

// File: tb/sim_dram_pwrup_seq.sv
`timescale 1ns/1ps
module sim_dram_pwrup_seq;

  localparam int         STABLE_CYC = 40;
  localparam int         TRP        = 3;
  localparam int         TMRD       = 2;
  localparam int         TRFC       = 8;
  localparam int         REF_NUM    = 2;  // table below lists two refreshes
  localparam logic [2:0] BL_CODE    = 3'b010;
  localparam logic       BT         = 1'b1;
  localparam logic [2:0] CL_CODE    = 3'b011;
  localparam logic       HALF_DRV   = 1'b1;

  localparam int         MODE_I = int'(CL_CODE) * 16 + int'(BT) * 8 + int'(BL_CODE);
  localparam logic [12:0] MODE  = 13'(MODE_I);

  // step = {pins[3:0], ba[1:0], addr[12:0], gap[11:0]}; pins 1111 marks "done rises"
  localparam logic [30:0] STEPS [7] = '{
    {4'b0010, 2'b00, 13'h0400,         12'(1)},
    {4'b0000, 2'b01, 13'(HALF_DRV) << 1, 12'(TRP)},
    {4'b0000, 2'b00, MODE | 13'h0100,  12'(TMRD)},
    {4'b0001, 2'b00, 13'h0000,         12'(TMRD)},
    {4'b0001, 2'b00, 13'h0000,         12'(TRFC)},
    {4'b0000, 2'b00, MODE,             12'(TRFC)},
    {4'b1111, 2'b00, 13'h0000,         12'(TMRD)}
  };
  string stepReq [7] = '{"R2", "R3", "R4", "R5", "R5", "R6", "R7"};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke, csN, rasN, casN, weN, done;
  logic [1:0]  ba;
  logic [12:0] addr;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  dram_pwrup_seq #(
    .STABLE_CYC (STABLE_CYC), .TRP (TRP), .TMRD (TMRD), .TRFC (TRFC),
    .REF_NUM (REF_NUM), .ADDR_W (13), .BA_W (2), .BL_CODE (BL_CODE),
    .BT (BT), .CL_CODE (CL_CODE), .HALF_DRV (HALF_DRV)
  ) u0 (
    .clk (clk), .rstN (rstN), .cke (cke), .csN (csN), .rasN (rasN),
    .casN (casN), .weN (weN), .ba (ba), .addr (addr), .done (done)
  );

  function automatic logic [3:0] pinsNow();
    return {csN, rasN, casN, weN};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkIdle(input string req);
    chk(cke == 1'b0, req, int'(cke), 0);
    chk(done == 1'b0, req, int'(done), 0);
    chk(pinsNow() == 4'b0111, req, int'(pinsNow()), 7);
  endtask

  // release reset and follow the series; abortAt > 0 stops after that edge
  task automatic runSeq(input int abortAt);
    int e;
    int prev;
    bit quiet;
    e = 0;
    quiet = 1'b1;
    @(posedge clk); #1 rstN = 1'b1;
    do begin
      @(posedge clk); #1;
      e++;
      if (!cke && (pinsNow() != 4'b0111 || done)) quiet = 1'b0;
    end while (!cke && e < 1000);
    chk(quiet, "R1", int'(quiet), 1);
    chk(e == STABLE_CYC, "R1", e, STABLE_CYC);
    prev = e;
    for (int s = 0; s < 7; s++) begin
      logic [30:0] st;
      bit hit;
      bit between;
      st = STEPS[s];
      hit = 1'b0;
      between = 1'b1;
      while (!hit && (e - prev) < 500) begin
        @(posedge clk); #1;
        e++;
        if (abortAt > 0 && e >= abortAt) return;
        if (st[30:27] == 4'b1111) hit = done;
        else                      hit = (pinsNow() != 4'b0111);
        if (!hit && (pinsNow() != 4'b0111 || !cke || done)) between = 1'b0;
      end
      chk(e - prev == int'(st[11:0]), stepReq[s], e - prev, int'(st[11:0]));
      chk(between, "R8", int'(between), 1);
      if (st[30:27] != 4'b1111) begin
        chk(pinsNow() == st[30:27], stepReq[s], int'(pinsNow()), int'(st[30:27]));
        chk(ba == st[26:25], stepReq[s], int'(ba), int'(st[26:25]));
        chk(addr == st[24:12], stepReq[s], int'(addr), int'(st[24:12]));
      end
      prev = e;
    end
    begin
      bit held;
      held = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(posedge clk); #1;
        if (!done || pinsNow() != 4'b0111 || !cke) held = 1'b0;
      end
      chk(held, "R7", int'(held), 1);
      chk(cke == 1'b1, "R9", int'(cke), 1);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // reset state (R1)
    repeat (3) @(posedge clk);
    #1;
    checkIdle("R1");
    // full series, table-driven
    runSeq(0);
    // reset during the refresh spacing (R10)
    #1 rstN = 1'b0;
    runSeq(STABLE_CYC + 20);
    #1 rstN = 1'b0;
    #1;
    checkIdle("R10");
    @(posedge clk); #1;
    checkIdle("R10");
    // restart after mid-series reset (R10)
    runSeq(0);
    // reset after done (R10)
    #1 rstN = 1'b0;
    #1;
    checkIdle("R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule